// File: doc/BRIEF.md
# Lane Execution-Mask Controller

This block holds the active-lane mask for a 64-lane vector unit driven by a single scalar sequencer. Divergent control flow is handled without a hardware stack. Each structured operation (IF, ELSE, END_CF, BREAK, IF_BREAK, ELSE_BREAK, LOOP and a direct mask write) is applied as one fixed AND/XOR/OR/AND-NOT step on the mask. Any lanes that must be restored later come back as a 64-bit token. The caller keeps that token, for example in scalar registers, and passes it back on the operation that consumes it.

Each operation is offered for one cycle with a valid strobe, an opcode, a 64-bit condition/operand vector, a token input and a modified-mask flag. The block applies the operation on the clock edge at which the strobe is high. After that edge it shows the new mask, the returned token, a skip-body flag, a loop-again flag and a scalar non-zero flag. These results hold until the next valid operation.

Top module: `lane_mask_ctrl`

## Requirements
- R1: After reset the mask is all ones, the token output is zero, and the skip, loop and non-zero flags are 0.
- R2: IF (opcode 0) sets mask = mask AND operand. Its token is the lanes that were active before the operation and are now off.
- R3: ELSE (opcode 1) ORs the token input into the mask, then removes the lanes that were active before it. The returned token is those previously active lanes. The modified-mask flag gives the same mask and token.
- R4: After IF or ELSE the skip flag is 1 exactly when the resulting mask is zero.
- R5: Every other valid operation clears the skip flag.
- R6: END_CF (opcode 2) sets mask = mask OR token input. The token output keeps its previous value.
- R7: BREAK (opcode 3) returns token input OR current mask, and leaves the mask unchanged.
- R8: IF_BREAK (opcode 4) and ELSE_BREAK (opcode 7) return token input OR operand, and leave the mask unchanged.
- R9: LOOP (opcode 5) sets mask = mask AND NOT token input. The loop flag is 1 exactly when that result is non-zero. Every other operation clears the loop flag.
- R10: WRITE (opcode 6) loads the operand into the mask.
- R11: The non-zero flag reports whether the result was non-zero. The result is the new token for opcodes 3, 4 and 7, and the new mask for all other opcodes.
- R12: While the valid strobe is low, no output changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Operation strobe, one cycle per operation |
| opCode | input | 3 | Operation code |
| opMask | input | 64 | Lane condition or operand vector |
| tokIn | input | 64 | Saved-lane token consumed by the operation |
| modExec | input | 1 | Modified-mask flag for ELSE |
| execMask | output | 64 | Current active-lane mask |
| tokOut | output | 64 | Token returned by the last producing operation |
| skipBody | output | 1 | No lane active after IF/ELSE |
| loopBack | output | 1 | Lanes remain after LOOP |
| sccFlag | output | 1 | Last result non-zero |

## Verification
The hardest state to reach is a two-level nest in which the inner ELSE gets a token whose lanes only partly overlap the outer condition. The final END_CF must then bring back exactly the full mask. The stimulus chains two IF operations with interleaved conditions. It then feeds each returned token back to its own ELSE and END_CF, in order. It also runs a loop in which breaks from IF_BREAK, BREAK and ELSE_BREAK retire lane groups until the loop flag falls. One empty IF drives the skip flag high.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;
  typedef enum logic [2:0] {
    OP_IF      = 3'd0,
    OP_ELSE    = 3'd1,
    OP_ENDCF   = 3'd2,
    OP_BREAK   = 3'd3,
    OP_IFBRK   = 3'd4,
    OP_LOOP    = 3'd5,
    OP_WRITE   = 3'd6,
    OP_ELSEBRK = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    EX_KEEP, EX_AND, EX_ELSE, EX_OR, EX_ANDN, EX_LOAD
  } exec_sel_e;

  typedef enum logic [1:0] {
    TK_KEEP, TK_IF, TK_ELSE, TK_ACC
  } tok_sel_e;

  typedef struct packed {
    logic      upd;
    exec_sel_e execSel;
    tok_sel_e  tokSel;
    logic      accExec;
    logic      skipEn;
    logic      loopEn;
    logic      resFromTok;
  } strobe_t;
endpackage

// File: rtl/lane_mask_decode.sv
module lane_mask_decode
  import lane_mask_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opCode,
  output strobe_t    st
);
  op_e op;
  assign op = op_e'(opCode);

  always_comb begin
    st = '{upd: 1'b0, execSel: EX_KEEP, tokSel: TK_KEEP, accExec: 1'b0,
           skipEn: 1'b0, loopEn: 1'b0, resFromTok: 1'b0};
    if (opValid) begin
      st.upd = 1'b1;
      unique case (op)
        OP_IF:      begin st.execSel = EX_AND;  st.tokSel = TK_IF;   st.skipEn = 1'b1; end
        OP_ELSE:    begin st.execSel = EX_ELSE; st.tokSel = TK_ELSE; st.skipEn = 1'b1; end
        OP_ENDCF:   st.execSel = EX_OR;
        OP_BREAK:   begin st.tokSel = TK_ACC; st.accExec = 1'b1; st.resFromTok = 1'b1; end
        OP_IFBRK,
        OP_ELSEBRK: begin st.tokSel = TK_ACC; st.resFromTok = 1'b1; end
        OP_LOOP:    begin st.execSel = EX_ANDN; st.loopEn = 1'b1; end
        OP_WRITE:   st.execSel = EX_LOAD;
        default:    st.execSel = EX_KEEP;
      endcase
    end
  end
endmodule

// File: rtl/lane_mask_datapath.sv
module lane_mask_datapath
  import lane_mask_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [LANES-1:0] opMask,
  input  logic [LANES-1:0] tokIn,
  input  logic             modExec,
  output logic [LANES-1:0] execQ,
  output logic [LANES-1:0] tokQ,
  output logic             skipQ,
  output logic             loopQ,
  output logic             sccQ
);
  localparam logic [LANES-1:0] ALL_ON = {LANES{1'b1}};

  logic [LANES-1:0] orExec, elseTok, accOp, nextExec, nextTok;

  always_comb begin
    orExec  = execQ | tokIn;
    elseTok = modExec ? (execQ & orExec) : execQ;
    accOp   = st.accExec ? execQ : opMask;
    unique case (st.execSel)
      EX_AND:  nextExec = execQ & opMask;
      EX_ELSE: nextExec = orExec ^ elseTok;
      EX_OR:   nextExec = orExec;
      EX_ANDN: nextExec = execQ & ~tokIn;
      EX_LOAD: nextExec = opMask;
      default: nextExec = execQ;
    endcase
    unique case (st.tokSel)
      TK_IF:   nextTok = nextExec ^ execQ;
      TK_ELSE: nextTok = elseTok;
      TK_ACC:  nextTok = tokIn | accOp;
      default: nextTok = tokQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      execQ <= ALL_ON;
      tokQ  <= '0;
      skipQ <= 1'b0;
      loopQ <= 1'b0;
      sccQ  <= 1'b0;
    end else if (st.upd) begin
      execQ <= nextExec;
      tokQ  <= nextTok;
      skipQ <= st.skipEn & (nextExec == '0);
      loopQ <= st.loopEn & (nextExec != '0);
      sccQ  <= st.resFromTok ? (nextTok != '0) : (nextExec != '0);
    end
  end

  // R2: IF splits the old mask into kept lanes and token lanes
  a_r2_if_split: assert property (@(posedge clk) disable iff (!rstN)
    (st.upd && st.execSel == EX_AND) |=>
      ((execQ & tokQ) == '0) && ((execQ | tokQ) == $past(execQ)));

  // R4: skip indication only with an empty mask
  a_r4_skip_empty: assert property (@(posedge clk) disable iff (!rstN)
    skipQ |-> (execQ == '0));

  // R6: END_CF never removes a lane
  a_r6_endcf_grow: assert property (@(posedge clk) disable iff (!rstN)
    (st.upd && st.execSel == EX_OR) |=> (($past(execQ) & ~execQ) == '0));

  // R9: loop-again only while lanes remain
  a_r9_loop_live: assert property (@(posedge clk) disable iff (!rstN)
    loopQ |-> (execQ != '0));

  // R12: idle cycles leave state alone
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.upd |=> ($stable(execQ) && $stable(tokQ) && $stable(sccQ)));
endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl
  import lane_mask_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  logic [63:0] opMask,
  input  logic [63:0] tokIn,
  input  logic        modExec,
  output logic [63:0] execMask,
  output logic [63:0] tokOut,
  output logic        skipBody,
  output logic        loopBack,
  output logic        sccFlag
);
  strobe_t st;

  lane_mask_decode i_decode (
    .opValid (opValid),
    .opCode  (opCode),
    .st      (st)
  );

  lane_mask_datapath #(.LANES(64)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .opMask  (opMask),
    .tokIn   (tokIn),
    .modExec (modExec),
    .execQ   (execMask),
    .tokQ    (tokOut),
    .skipQ   (skipBody),
    .loopQ   (loopBack),
    .sccQ    (sccFlag)
  );
endmodule

// File: tb/test_lane_mask_ctrl.sv
`timescale 1ns/1ps
module test_lane_mask_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [63:0] opMask = '0;
  logic [63:0] tokIn = '0;
  logic        modExec = 1'b0;
  logic [63:0] execMask, tokOut;
  logic        skipBody, loopBack, sccFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] mE = '1, mT = '0;
  logic        mSk = 1'b0, mLp = 1'b0, mSc = 1'b0;

  always #2.5 clk = ~clk;

  lane_mask_ctrl i_lane_mask_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opMask(opMask), .tokIn(tokIn), .modExec(modExec),
    .execMask(execMask), .tokOut(tokOut), .skipBody(skipBody),
    .loopBack(loopBack), .sccFlag(sccFlag)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chkAll(string req);
    chk(req, "execMask", execMask, mE);
    chk(req, "tokOut", tokOut, mT);
    chk(req, "skipBody", 64'(skipBody), 64'(mSk));
    chk(req, "loopBack", 64'(loopBack), 64'(mLp));
    chk(req, "sccFlag", 64'(sccFlag), 64'(mSc));
  endtask

  task automatic doOp(logic [2:0] op, logic [63:0] m, logic [63:0] tin, logic me, string req);
    logic [63:0] ne, nt, o;
    logic resT;
    ne = mE; nt = mT; resT = 1'b0; mSk = 1'b0; mLp = 1'b0;
    case (op)
      3'd0: begin ne = mE & m; nt = ne ^ mE; mSk = (ne == '0); end
      3'd1: begin o = mE | tin; nt = me ? (mE & o) : mE; ne = o ^ nt; mSk = (ne == '0); end
      3'd2: ne = mE | tin;
      3'd3: begin nt = tin | mE; resT = 1'b1; end
      3'd4, 3'd7: begin nt = tin | m; resT = 1'b1; end
      3'd5: begin ne = mE & ~tin; mLp = (ne != '0); end
      default: ne = m;
    endcase
    mSc = resT ? (nt != '0) : (ne != '0);
    mE = ne; mT = nt;
    @(negedge clk);
    opValid = 1'b1; opCode = op; opMask = m; tokIn = tin; modExec = me;
    @(negedge clk);
    opValid = 1'b0; opMask = ~m; tokIn = ~tin; opCode = ~op;
    chkAll(req);
  endtask

  task automatic t_reset();
    chkAll("R1");
  endtask

  task automatic t_nested();
    logic [63:0] tA, tB, tE1, tE2;
    doOp(3'd0, 64'h00FF_00FF_F0F0_1234, '0, 1'b0, "R2"); tA = mT;
    doOp(3'd0, 64'h0F0F_0F0F_0F0F_0F0F, '0, 1'b0, "R2"); tB = mT;
    doOp(3'd1, '0, tB, 1'b0, "R3"); tE1 = mT;
    doOp(3'd2, '0, tE1, 1'b0, "R6");
    doOp(3'd1, '0, tA, 1'b1, "R3"); tE2 = mT;
    doOp(3'd2, '0, tE2, 1'b0, "R6");
    chk("R6", "restored", execMask, '1);
  endtask

  task automatic t_skip();
    logic [63:0] t;
    doOp(3'd6, 64'hA5A5_0000_FFFF_0001, '0, 1'b0, "R10");
    doOp(3'd0, 64'h5A5A_FFFF_0000_0000, '0, 1'b0, "R4"); t = mT;
    chk("R4", "skip raised", 64'(skipBody), 64'd1);
    doOp(3'd1, '0, t, 1'b0, "R3"); t = mT;
    doOp(3'd2, '0, t, 1'b0, "R5");
    chk("R5", "skip cleared", 64'(skipBody), 64'd0);
    doOp(3'd6, '0, '0, 1'b0, "R11");
    chk("R11", "zero result", 64'(sccFlag), 64'd0);
    doOp(3'd6, '1, '0, 1'b0, "R10");
  endtask

  task automatic t_loop();
    logic [63:0] brk;
    brk = '0;
    doOp(3'd4, 64'h0000_0000_0000_FFFF, brk, 1'b0, "R8"); brk = mT;
    doOp(3'd5, '0, brk, 1'b0, "R9");
    chk("R9", "loop again", 64'(loopBack), 64'd1);
    doOp(3'd7, 64'h0000_0000_FFFF_0000, brk, 1'b0, "R8"); brk = mT;
    doOp(3'd5, '0, brk, 1'b0, "R9");
    doOp(3'd0, 64'h0000_FFFF_0000_0000, '0, 1'b0, "R2");
    doOp(3'd3, '0, brk, 1'b0, "R7"); brk = mT;
    doOp(3'd6, 64'hFFFF_FFFF_0000_0000, '0, 1'b0, "R10");
    doOp(3'd5, '0, brk, 1'b0, "R9");
    doOp(3'd4, 64'hFFFF_0000_0000_0000, brk, 1'b0, "R8"); brk = mT;
    doOp(3'd5, '0, brk, 1'b0, "R9");
    chk("R9", "loop exit", 64'(loopBack), 64'd0);
    doOp(3'd2, '0, brk, 1'b0, "R6");
  endtask

  task automatic t_idle();
    doOp(3'd0, 64'h1234_5678_9ABC_DEF0, '0, 1'b0, "R2");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      opMask = {2{32'(i * 7 + 3)}}; tokIn = '1; opCode = 3'(i);
    end
    chkAll("R12");
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_nested();
    t_skip();
    t_loop();
    t_idle();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule